// File: doc/BRIEF.md
# Receive Payload Nibble Output Interface

This block hands recovered receive payload to terminal equipment. It runs on the receive line clock. An upstream framer offers it one line bit per cycle, tagged with an accept flag (`bit_valid`) and a flag for the first bit of a frame (`frame_start`). In serial mode the accepted bit is registered onto `ser_out`. The output clock is then the line clock itself. `frame_pulse` marks the first bit of each frame for one bit period.

In nibble mode, accepted bits are packed four at a time, first bit in the most significant position, into a small queue. A state machine turns each queued nibble into one pulse of a gapped output clock. Each pulse is two line cycles high and two low. No pulse is made while no nibble is waiting. The nibble changes only while the output clock is low. A frame flag resets the packer, so the first nibble of each frame starts on the frame boundary.

An audit counter counts pulses between frame boundaries. It compares each count with the number expected for the selected framing: DS3, E3 G.832 or E3 G.751. A mismatch sets a sticky error flag.

The pulse generator has six states:
- `ST_IDLE`: clock low, no nibble pending. It pops a waiting nibble and moves to `ST_SETUP`.
- `ST_SETUP`: one low cycle with the new data present. It moves to `ST_HI0`.
- `ST_HI0` moves to `ST_HI1`. Both states drive the clock high.
- `ST_HI1` moves to `ST_LO0` on the falling edge.
- `ST_LO0` pops the next nibble if one waits, then moves to `ST_LO1`.
- `ST_LO1` goes back to `ST_HI0` if a nibble was loaded, otherwise to `ST_IDLE`.

Top module: `rx_payload_egress`

## Requirements
- R1: With `nibble_mode`=0, `ser_out` shows the most recently accepted `bit_in` from the clock edge that accepts it (`bit_valid`=1) and holds otherwise. `out_clk` equals `clk`.
- R2: With `nibble_mode`=0, `frame_pulse` is high for exactly the one cycle following an edge that accepts a bit with `frame_start`=1, and low otherwise.
- R3: With `nibble_mode`=1, every four accepted bits form one nibble on `nib_out`, the first-accepted bit in bit 3 and the last in bit 0. Nibbles appear in arrival order.
- R4: An accepted bit with `frame_start`=1 discards any partly filled nibble and becomes bit 3 of a new nibble.
- R5: In nibble mode each `out_clk` pulse is exactly two `clk` cycles high, with at least two low cycles between pulses. A pulse occurs only when a completed nibble is waiting.
- R6: In nibble mode, `nib_out` never changes while `out_clk` is high, and is valid from the rising edge of each pulse.
- R7: In nibble mode, `frame_pulse` is high during the pulse that carries the first nibble of a frame and low during every other pulse.
- R8: `frame_type` 0 expects 1176 pulses per frame, 1 expects 1074, and 2 or 3 expects 384. When a frame's first nibble is issued, a previous frame boundary exists and the pulses since that boundary differ from the expected count, `count_err` goes to 1 and stays there until reset. Correct frames leave it at 0.
- R9: With at most one accepted bit per cycle, every completed nibble is delivered by exactly one pulse and none is lost.
- R10: While `rst_n` is low, `ser_out`, `nib_out`, `frame_pulse` and `count_err` are 0, and in nibble mode `out_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nibble_mode | input | 1 | 0 selects serial output, 1 selects 4-bit output |
| frame_type | input | 2 | 0 DS3, 1 E3 G.832, 2 or 3 E3 G.751 |
| bit_in | input | 1 | Line payload bit |
| bit_valid | input | 1 | Bit on `bit_in` is accepted this cycle |
| frame_start | input | 1 | Accepted bit is the first of a frame |
| ser_out | output | 1 | Serial payload bit |
| nib_out | output | 4 | Payload nibble |
| out_clk | output | 1 | Output clock: line clock or gapped nibble clock |
| frame_pulse | output | 1 | Marks the first bit or nibble of a frame |
| count_err | output | 1 | Sticky per-frame pulse count mismatch |

## Verification
The hardest condition to reach is the nibble queue under its heaviest load. That load comes from accepted bits on every cycle, arriving just after the generator has dropped to `ST_IDLE`, so that pulses and nibbles run at the same rate with a startup delay to absorb. The stimulus gets there by sending whole DS3 frames with no idle cycles, after randomly gapped frames that leave the generator in varied phases. A second hard case is a frame flag that arrives with a partial nibble pending, together with a short frame that must trip the sticky error. These are produced by directed frame lengths that are not multiples of four and not the nominal length.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HI0,
        ST_HI1,
        ST_LO0,
        ST_LO1
    } nclk_state_e;

    typedef struct packed {
        logic       first;
        logic [3:0] nib;
    } nib_entry_t;

endpackage

// File: rtl/rxp_packer.sv
module rxp_packer
    import rxp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bit_in,
    input  logic       bit_valid,
    input  logic       frame_start,
    output logic       push,
    output nib_entry_t push_data
);
    logic [1:0] fill_q;
    logic [2:0] shreg_q;
    logic       first_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            fill_q  <= '0;
            shreg_q <= '0;
            first_q <= 1'b0;
        end else if (bit_valid) begin
            if (frame_start) begin
                shreg_q <= {2'b00, bit_in};
                fill_q  <= 2'd1;
                first_q <= 1'b1;
            end else if (fill_q == 2'd3) begin
                fill_q  <= 2'd0;
                first_q <= 1'b0;
            end else begin
                shreg_q <= {shreg_q[1:0], bit_in};
                fill_q  <= fill_q + 2'd1;
            end
        end
    end

    always_comb begin
        push           = en && bit_valid && !frame_start && (fill_q == 2'd3);
        push_data.first = first_q;
        push_data.nib   = {shreg_q, bit_in};
    end
endmodule

// File: rtl/rxp_fifo.sv
module rxp_fifo
    import rxp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  nib_entry_t din,
    input  logic       pop,
    output nib_entry_t dout,
    output logic       empty,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

    nib_entry_t    mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push && !full) begin
                mem_q[wr_q] <= din;
                wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (pop && !empty) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + (AW + 1)'(push && !full) - (AW + 1)'(pop && !empty);
        end
    end

    assign dout  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == FULL_CNT);
endmodule

// File: rtl/rxp_nclk_gen.sv
module rxp_nclk_gen
    import rxp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       empty,
    input  nib_entry_t head,
    output logic       pop,
    output logic       nclk,
    output logic [3:0] nib_q,
    output logic       first_q
);
    nclk_state_e state_q, state_d;
    logic        loaded_q, loaded_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q  <= ST_IDLE;
            loaded_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            loaded_q <= loaded_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        loaded_d = loaded_q;
        pop      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en && !empty) begin
                    pop     = 1'b1;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: state_d = ST_HI0;
            ST_HI0:   state_d = ST_HI1;
            ST_HI1:   state_d = ST_LO0;
            ST_LO0: begin
                pop      = en && !empty;
                loaded_d = en && !empty;
                state_d  = ST_LO1;
            end
            ST_LO1:   state_d = loaded_q ? ST_HI0 : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        nclk = (state_q == ST_HI0) || (state_q == ST_HI1);
    end

    // launched data, updated only on pops made in low states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q   <= '0;
            first_q <= 1'b0;
        end else if (pop) begin
            nib_q   <= head.nib;
            first_q <= head.first;
        end
    end
endmodule

// File: rtl/rx_payload_egress.sv
module rx_payload_egress
    import rxp_pkg::*;
#(
    parameter int FIFO_DEPTH   = 4,
    parameter int DS3_PULSES   = 1176,
    parameter int G832_PULSES  = 1074,
    parameter int G751_PULSES  = 384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nibble_mode,
    input  logic [1:0] frame_type,
    input  logic       bit_in,
    input  logic       bit_valid,
    input  logic       frame_start,
    output logic       ser_out,
    output logic [3:0] nib_out,
    output logic       out_clk,
    output logic       frame_pulse,
    output logic       count_err
);
    localparam int CNT_W = $clog2(DS3_PULSES + 1);

    nib_entry_t pk_data_w, head_w;
    logic       pk_push_w, fifo_empty_w, fifo_full_w, pop_w, nclk_w, fp_nib_w;
    logic       ser_q, fp_ser_q, seen_q, err_q;
    logic [CNT_W-1:0] pulse_cnt_q, expect_w;

    rxp_packer u_packer (
        .clk(clk), .rst_n(rst_n), .en(nibble_mode),
        .bit_in(bit_in), .bit_valid(bit_valid), .frame_start(frame_start),
        .push(pk_push_w), .push_data(pk_data_w)
    );

    rxp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(pk_push_w), .din(pk_data_w),
        .pop(pop_w), .dout(head_w), .empty(fifo_empty_w), .full(fifo_full_w)
    );

    rxp_nclk_gen u_gen (
        .clk(clk), .rst_n(rst_n), .en(nibble_mode), .empty(fifo_empty_w),
        .head(head_w), .pop(pop_w), .nclk(nclk_w), .nib_q(nib_out),
        .first_q(fp_nib_w)
    );

    // serial path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q    <= 1'b0;
            fp_ser_q <= 1'b0;
        end else begin
            if (bit_valid) ser_q <= bit_in;
            fp_ser_q <= bit_valid && frame_start;
        end
    end

    // per-frame pulse audit
    always_comb begin
        unique case (frame_type)
            2'd0:    expect_w = CNT_W'(DS3_PULSES);
            2'd1:    expect_w = CNT_W'(G832_PULSES);
            default: expect_w = CNT_W'(G751_PULSES);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt_q <= '0;
            seen_q      <= 1'b0;
            err_q       <= 1'b0;
        end else if (pop_w) begin
            if (head_w.first) begin
                if (seen_q && (pulse_cnt_q != expect_w)) err_q <= 1'b1;
                pulse_cnt_q <= CNT_W'(1);
                seen_q      <= 1'b1;
            end else begin
                pulse_cnt_q <= pulse_cnt_q + 1'b1;
            end
        end
    end

    assign ser_out     = ser_q;
    assign out_clk     = nibble_mode ? nclk_w : clk;
    assign frame_pulse = nibble_mode ? fp_nib_w : fp_ser_q;
    assign count_err   = err_q;
endmodule

// File: rtl/rxp_egress_chk.sv
module rxp_egress_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nibble_mode,
    input logic       bit_in,
    input logic       bit_valid,
    input logic       ser_out,
    input logic       nclk,
    input logic [3:0] nib_out,
    input logic       fifo_push,
    input logic       fifo_full,
    input logic       count_err
);
    // R1: serial bit appears one edge after acceptance
    p_ser_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nibble_mode && bit_valid) |=> (ser_out == $past(bit_in)));

    // R5: a rising nibble clock stays high for a second cycle
    p_high_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nibble_mode && nclk && !$past(nclk)) |=> nclk);

    // R5: after two high cycles the nibble clock falls
    p_fall_after_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nibble_mode && nclk && $past(nclk)) |=> !nclk);

    // R6: nibble data is frozen while the clock is high
    p_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nibble_mode && nclk) |-> $stable(nib_out));

    // R9: the nibble queue is never pushed while full
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push);

    // R8: the count error is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count_err |=> count_err);
endmodule

bind rx_payload_egress rxp_egress_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .bit_in(bit_in),
    .bit_valid(bit_valid), .ser_out(ser_out), .nclk(nclk_w), .nib_out(nib_out),
    .fifo_push(pk_push_w), .fifo_full(fifo_full_w), .count_err(count_err)
);

// File: tb/rx_payload_egress_tb_top.sv
module rx_payload_egress_tb_top;
    localparam time CYC = 10ns;

    logic       clk = 1'b0;
    logic       rst_n, nibble_mode, bit_in, bit_valid, frame_start;
    logic [1:0] frame_type;
    logic       ser_out, out_clk, frame_pulse, count_err;
    logic [3:0] nib_out;

    int n_chk = 0, n_bad = 0;
    logic [4:0] exp_q[$];
    int   m_fill, f_cnt;
    logic [2:0] m_sh;
    bit   m_first, f_seen, m_err, mon_on;
    bit   prev_oc;
    int   hi_run, low_run;
    logic [3:0] cap_nib;

    always #(CYC/2) clk = ~clk;

    rx_payload_egress dut_i (
        .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .frame_type(frame_type),
        .bit_in(bit_in), .bit_valid(bit_valid), .frame_start(frame_start),
        .ser_out(ser_out), .nib_out(nib_out), .out_clk(out_clk),
        .frame_pulse(frame_pulse), .count_err(count_err)
    );

    function automatic int exp_pulses(logic [1:0] ft);
        case (ft)
            2'd0:    return 1176;
            2'd1:    return 1074;
            default: return 384;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_accept(logic b, logic fs);
        if (fs) begin
            m_sh = {2'b00, b}; m_fill = 1; m_first = 1'b1;
        end else if (m_fill == 3) begin
            exp_q.push_back({m_first, m_sh, b});
            if (m_first) begin
                if (f_seen && f_cnt != exp_pulses(frame_type)) m_err = 1'b1;
                f_cnt = 1; f_seen = 1'b1;
            end else f_cnt++;
            m_first = 1'b0; m_fill = 0;
        end else begin
            m_sh = {m_sh[1:0], b}; m_fill++;
        end
    endfunction

    task automatic apply_reset(logic mode, logic [1:0] ft);
        mon_on = 1'b0;
        rst_n = 1'b0; bit_valid = 1'b0; frame_start = 1'b0; bit_in = 1'b0;
        nibble_mode = mode; frame_type = ft;
        exp_q.delete(); m_fill = 0; m_sh = '0; m_first = 1'b0;
        f_cnt = 0; f_seen = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(ser_out == 1'b0 && frame_pulse == 1'b0, "R10 reset ser/frame", {ser_out, frame_pulse}, 0);
        check(nib_out == 4'd0 && count_err == 1'b0, "R10 reset nib/err", {nib_out, count_err}, 0);
        if (mode) check(out_clk == 1'b0, "R10 reset out_clk", out_clk, 0);
        @(negedge clk);
        rst_n = 1'b1;
        prev_oc = 1'b0; hi_run = 0; low_run = 2;
        mon_on = mode;
    endtask

    task automatic drive_bit(logic b, logic fs, int gap_pct);
        while ($urandom_range(99) < gap_pct) begin
            bit_valid = 1'b0; frame_start = 1'b0;
            @(negedge clk);
        end
        bit_valid = 1'b1; bit_in = b; frame_start = fs;
        @(posedge clk);
        model_accept(b, fs);
        @(negedge clk);
    endtask

    task automatic send_frame(int nbits, int gap_pct);
        for (int i = 0; i < nbits; i++) drive_bit(1'($urandom_range(1)), i == 0, gap_pct);
    endtask

    task automatic drain_and_check(string tag);
        bit_valid = 1'b0; frame_start = 1'b0;
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R9 all nibbles delivered", exp_q.size(), 0);
        check(count_err == m_err, {"R8 count_err ", tag}, count_err, m_err);
    endtask

    // nibble-mode monitor, sampling mid-cycle
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_clk && !prev_oc) begin
                check(low_run >= 2, "R5 low time before pulse", low_run, 2);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 R9 pulse without nibble", 1, 0);
                end else begin
                    logic [4:0] e;
                    e = exp_q.pop_front();
                    check(nib_out == e[3:0], "R3 R4 nibble value", nib_out, e[3:0]);
                    check(frame_pulse == e[4], "R7 frame marker", frame_pulse, e[4]);
                end
                cap_nib = nib_out; hi_run = 1;
            end else if (out_clk) begin
                hi_run++;
                check(nib_out == cap_nib, "R6 nibble stable while high", nib_out, cap_nib);
            end else if (prev_oc) begin
                check(hi_run == 2, "R5 high width", hi_run, 2);
                low_run = 1;
            end else begin
                low_run++;
            end
            prev_oc = out_clk;
        end
    end

    initial begin
        #(CYC * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic exp_ser;
        void'($urandom(32'd1234));

        // serial mode: R1, R2
        apply_reset(1'b0, 2'd0);
        exp_ser = 1'b0;
        for (int i = 0; i < 300; i++) begin
            logic v, b, fs;
            v  = ($urandom_range(3) != 0);
            b  = 1'($urandom_range(1));
            fs = v && ($urandom_range(31) == 0);
            bit_valid = v; bit_in = b; frame_start = fs;
            @(posedge clk); #1;
            check(out_clk == 1'b1, "R1 out_clk high phase", out_clk, 1);
            @(negedge clk); #1;
            check(out_clk == 1'b0, "R1 out_clk low phase", out_clk, 0);
            if (v) exp_ser = b;
            check(ser_out == exp_ser, "R1 serial bit", ser_out, exp_ser);
            check(frame_pulse == (v && fs), "R2 serial frame pulse", frame_pulse, v && fs);
        end

        // G.751: stray bits, good frames, short unaligned frame, sticky error
        apply_reset(1'b1, 2'd2);
        for (int i = 0; i < 6; i++) drive_bit(1'($urandom_range(1)), 1'b0, 30);
        send_frame(1536, 30);
        send_frame(1536, 40);
        send_frame(1502, 20);
        drain_and_check("after good G.751 frames");
        send_frame(1536, 30);
        send_frame(4, 0);
        drain_and_check("after short G.751 frame");
        check(count_err == 1'b1, "R8 sticky after later good frame", count_err, 1);

        // DS3: gap-free frames stress the queue
        apply_reset(1'b1, 2'd0);
        send_frame(4704, 0);
        send_frame(4704, 0);
        send_frame(4, 0);
        drain_and_check("DS3 gap-free");
        check(count_err == 1'b0, "R8 DS3 correct length", count_err, 0);

        // G.832: correct frames then a wrong-length one
        apply_reset(1'b1, 2'd1);
        send_frame(4296, 25);
        send_frame(4296, 0);
        send_frame(4, 0);
        drain_and_check("G.832 correct");
        send_frame(4704, 10);
        send_frame(4, 0);
        drain_and_check("G.832 DS3-length frame");
        check(count_err == 1'b1, "R8 G.832 mismatch flagged", count_err, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule